// File: doc/BRIEF.md
# Dual-Accumulator 40-bit ALU

This block is a two's-complement arithmetic and logic unit, 40 bits wide, that writes its result into one of two accumulators. Each accumulator is split into an 8-bit guard field (bits 39..32), a 16-bit high word (bits 31..16) and a 16-bit low word (bits 15..0). The first operand is always the current value of the destination accumulator. The second operand can come from several places: a 16-bit immediate, a 16-bit memory word, a 16-bit temporary register, a pair of 16-bit words, a 32-bit memory word, or either accumulator. The available operations are add, subtract, AND, OR, XOR and move.

A field-select input limits the write to one part of the accumulator: the guard field, the high word, the low word, the 32-bit word, or all 40 bits. This lets software load or update one part without disturbing the rest. In split mode the unit behaves as two independent 16-bit ALUs, one working on the high words and one on the low words, with no carry passing between them. A combinational read port returns any field of either accumulator, right-aligned.

The result is registered on a single clock edge. It is written only when the write-enable input is high and the operation and field codes are legal.

Top module: `dual_acc_alu`

## Requirements
- R1: While reset is active, and on release of reset, both accumulators hold zero.
- R2: A 16-bit operand (source codes 0 immediate, 1 memory word, 2 temporary register) is sign-extended to 40 bits when signExt is 1 and zero-extended when it is 0.
- R3: A 32-bit operand (source code 3 for the pair, with pairHi in bits 31..16 and pairLo in bits 15..0; source code 4 for memLong) is extended from bit 31 to 40 bits according to signExt.
- R4: Operation codes 0 (add: dst + src) and 1 (subtract: dst - src) compute modulo 2^40, so a carry or borrow propagates into the guard bits.
- R5: Operation codes 2, 3 and 4 give the bitwise AND, OR and XOR of dst and src over all 40 bits; code 5 (move) gives src.
- R6: dstSel 0 writes accumulator A and dstSel 1 writes accumulator B; the other accumulator never changes.
- R7: With wrEn 0, with a reserved operation code (6 or 7), or with a reserved field code (5 to 7) outside split mode, neither accumulator changes.
- R8: fieldSel 0 writes bits 39..0, 1 writes 31..0, 2 writes 31..16, 3 writes 15..0 and 4 writes 39..32, each from the same bit positions of the result. All other bits are kept.
- R9: With splitMode 1, the high and low words are each computed as separate 16-bit operations with no carry between them, both words are written, the guard field is kept and fieldSel is ignored. A 16-bit source feeds both lanes; a 32-bit source or an accumulator feeds its upper word to the high lane and its lower word to the low lane.
- R10: Source codes 5 and 6 select accumulator A and accumulator B as the operand, so a move copies one accumulator into the other.
- R11: rdData returns the accumulator chosen by rdSel (0 A, 1 B), shaped by rdField: 0 all 40 bits, 1 bits 31..0, 2 bits 31..16, 3 bits 15..0, 4 bits 39..32, each right-aligned and zero-padded. Codes 5 to 7 return zero.
- R12: A write becomes visible on accA/accB only after the next rising clock edge, never while the operands are being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Commit the result on this clock edge |
| aluOp | input | 3 | Operation code |
| srcSel | input | 3 | Second-operand source code |
| dstSel | input | 1 | Destination accumulator (0 A, 1 B) |
| fieldSel | input | 3 | Accumulator field to write |
| splitMode | input | 1 | Two independent 16-bit lanes |
| signExt | input | 1 | Sign-extend (1) or zero-extend (0) narrow operands |
| immVal | input | 16 | Immediate operand |
| memWord | input | 16 | 16-bit memory operand |
| tempReg | input | 16 | Temporary register operand |
| pairHi | input | 16 | Upper word of the operand pair |
| pairLo | input | 16 | Lower word of the operand pair |
| memLong | input | 32 | 32-bit memory operand |
| rdSel | input | 1 | Accumulator shown on rdData |
| rdField | input | 3 | Field shown on rdData |
| accA | output | 40 | Accumulator A |
| accB | output | 40 | Accumulator B |
| rdData | output | 40 | Selected field, right-aligned |

## Verification
The assertions check the following on every cycle. An idle cycle leaves both accumulators unchanged. A write never touches the non-selected accumulator. A low-word write preserves bits 39..16. A split write preserves the guard field. A full move between accumulators produces an exact copy.

Only the bench scenarios can show that the values themselves are right. That covers sign and zero extension, the 40-bit carry into the guard bits, the absence of a carry between lanes in split mode, the Boolean results and the shaping of the read port, all of which the bench checks against its own model after each edge.

// File: rtl/dual_acc_pkg.sv
package dual_acc_pkg;

  localparam int DEF_WORD_W  = 16;
  localparam int DEF_GUARD_W = 8;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_MOVE = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } aluOp_e;

  typedef enum logic [2:0] {
    SRC_IMM   = 3'd0,
    SRC_MEM16 = 3'd1,
    SRC_TREG  = 3'd2,
    SRC_PAIR  = 3'd3,
    SRC_MEM32 = 3'd4,
    SRC_ACCA  = 3'd5,
    SRC_ACCB  = 3'd6,
    SRC_NONE  = 3'd7
  } srcSel_e;

  typedef enum logic [2:0] {
    FLD_FULL  = 3'd0,
    FLD_WORD  = 3'd1,
    FLD_HIGH  = 3'd2,
    FLD_LOW   = 3'd3,
    FLD_GUARD = 3'd4,
    FLD_RSV5  = 3'd5,
    FLD_RSV6  = 3'd6,
    FLD_RSV7  = 3'd7
  } field_e;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_NARROW = 2'd1,
    KIND_WIDE   = 2'd2,
    KIND_ACC    = 2'd3
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [1:0] accWr;
    logic       guardWr;
    logic       highWr;
    logic       lowWr;
    logic       split;
    aluOp_e     op;
  } strobe_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import dual_acc_pkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] aluOp,
  input  logic       dstSel,
  input  logic [2:0] fieldSel,
  input  logic       splitMode,
  output strobe_t    strobe
);

  logic opLegal;
  logic fieldLegal;
  logic commit;

  assign opLegal    = (aluOp <= 3'd5);
  assign fieldLegal = (fieldSel <= 3'd4);
  assign commit     = wrEn && opLegal && (splitMode || fieldLegal);

  always_comb begin
    strobe.op      = aluOp_e'(aluOp);
    strobe.split   = splitMode;
    strobe.accWr   = 2'b00;
    strobe.guardWr = 1'b0;
    strobe.highWr  = 1'b0;
    strobe.lowWr   = 1'b0;
    if (commit) begin
      strobe.accWr = dstSel ? 2'b10 : 2'b01;
    end
    if (splitMode) begin
      strobe.highWr = 1'b1;
      strobe.lowWr  = 1'b1;
    end else begin
      case (field_e'(fieldSel))
        FLD_FULL: begin
          strobe.guardWr = 1'b1;
          strobe.highWr  = 1'b1;
          strobe.lowWr   = 1'b1;
        end
        FLD_WORD: begin
          strobe.highWr = 1'b1;
          strobe.lowWr  = 1'b1;
        end
        FLD_HIGH:  strobe.highWr  = 1'b1;
        FLD_LOW:   strobe.lowWr   = 1'b1;
        FLD_GUARD: strobe.guardWr = 1'b1;
        default: begin
          strobe.guardWr = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/acc_field_reg.sv
module acc_field_reg
  import dual_acc_pkg::*;
#(
  parameter int WORD_W  = DEF_WORD_W,
  parameter int GUARD_W = DEF_GUARD_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic                              guardWr,
  input  logic                              highWr,
  input  logic                              lowWr,
  input  logic [GUARD_W+2*WORD_W-1:0]       dIn,
  output logic [GUARD_W+2*WORD_W-1:0]       qOut
);

  localparam int DBL_W = 2 * WORD_W;
  localparam int ACC_W = GUARD_W + DBL_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qOut <= '0;
    end else if (wrEn) begin
      if (guardWr) qOut[ACC_W-1:DBL_W]  <= dIn[ACC_W-1:DBL_W];
      if (highWr)  qOut[DBL_W-1:WORD_W] <= dIn[DBL_W-1:WORD_W];
      if (lowWr)   qOut[WORD_W-1:0]     <= dIn[WORD_W-1:0];
    end
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import dual_acc_pkg::*;
#(
  parameter int WORD_W  = DEF_WORD_W,
  parameter int GUARD_W = DEF_GUARD_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobe,
  input  logic [2:0]                   srcSel,
  input  logic                         dstSel,
  input  logic                         signExt,
  input  logic [WORD_W-1:0]            immVal,
  input  logic [WORD_W-1:0]            memWord,
  input  logic [WORD_W-1:0]            tempReg,
  input  logic [WORD_W-1:0]            pairHi,
  input  logic [WORD_W-1:0]            pairLo,
  input  logic [2*WORD_W-1:0]          memLong,
  input  logic                         rdSel,
  input  logic [2:0]                   rdField,
  output logic [GUARD_W+2*WORD_W-1:0]  accA,
  output logic [GUARD_W+2*WORD_W-1:0]  accB,
  output logic [GUARD_W+2*WORD_W-1:0]  rdData
);

  localparam int DBL_W  = 2 * WORD_W;
  localparam int ACC_W  = GUARD_W + DBL_W;
  localparam int EXT_N  = ACC_W - WORD_W;
  localparam int LANE_N = 2;

  logic [ACC_W-1:0]             accQ [LANE_N];
  logic [ACC_W-1:0]             dstVal;
  logic [ACC_W-1:0]             accOpnd;
  logic [ACC_W-1:0]             opndFull;
  logic [ACC_W-1:0]             fullRes;
  logic [ACC_W-1:0]             resVal;
  logic [ACC_W-1:0]             rdSrc;
  logic [WORD_W-1:0]            narrowVal;
  logic [DBL_W-1:0]             wideVal;
  opKind_e                      opKind;
  logic [LANE_N-1:0][WORD_W-1:0] laneOpnd;
  logic [LANE_N-1:0][WORD_W-1:0] laneDst;
  logic [LANE_N-1:0][WORD_W-1:0] laneRes;

  function automatic logic [ACC_W-1:0] fullAlu(aluOp_e op, logic [ACC_W-1:0] a,
                                               logic [ACC_W-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return b;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] laneAlu(aluOp_e op, logic [WORD_W-1:0] a,
                                                logic [WORD_W-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return b;
    endcase
  endfunction

  // Source selection
  always_comb begin
    narrowVal = '0;
    wideVal   = '0;
    accOpnd   = '0;
    opKind    = KIND_NONE;
    case (srcSel_e'(srcSel))
      SRC_IMM:   begin narrowVal = immVal;  opKind = KIND_NARROW; end
      SRC_MEM16: begin narrowVal = memWord; opKind = KIND_NARROW; end
      SRC_TREG:  begin narrowVal = tempReg; opKind = KIND_NARROW; end
      SRC_PAIR:  begin wideVal = {pairHi, pairLo}; opKind = KIND_WIDE; end
      SRC_MEM32: begin wideVal = memLong; opKind = KIND_WIDE; end
      SRC_ACCA:  begin accOpnd = accQ[0]; opKind = KIND_ACC; end
      SRC_ACCB:  begin accOpnd = accQ[1]; opKind = KIND_ACC; end
      default:   opKind = KIND_NONE;
    endcase
  end

  // Operand shaping: full width and per-lane halves
  always_comb begin
    case (opKind)
      KIND_NARROW: begin
        opndFull    = {{EXT_N{signExt & narrowVal[WORD_W-1]}}, narrowVal};
        laneOpnd[1] = narrowVal;
        laneOpnd[0] = narrowVal;
      end
      KIND_WIDE: begin
        opndFull    = {{GUARD_W{signExt & wideVal[DBL_W-1]}}, wideVal};
        laneOpnd[1] = wideVal[DBL_W-1:WORD_W];
        laneOpnd[0] = wideVal[WORD_W-1:0];
      end
      KIND_ACC: begin
        opndFull    = accOpnd;
        laneOpnd[1] = accOpnd[DBL_W-1:WORD_W];
        laneOpnd[0] = accOpnd[WORD_W-1:0];
      end
      default: begin
        opndFull = '0;
        laneOpnd = '0;
      end
    endcase
  end

  assign dstVal  = dstSel ? accQ[1] : accQ[0];
  assign fullRes = fullAlu(strobe.op, dstVal, opndFull);

  // Two independent 16-bit lanes for split mode
  for (genvar l = 0; l < LANE_N; l++) begin : gLane
    assign laneDst[l] = dstVal[l*WORD_W +: WORD_W];
    assign laneRes[l] = laneAlu(strobe.op, laneDst[l], laneOpnd[l]);
  end

  assign resVal = strobe.split ? {dstVal[ACC_W-1:DBL_W], laneRes} : fullRes;

  // Accumulator storage
  for (genvar a = 0; a < LANE_N; a++) begin : gAcc
    acc_field_reg #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) uReg (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (strobe.accWr[a]),
      .guardWr (strobe.guardWr),
      .highWr  (strobe.highWr),
      .lowWr   (strobe.lowWr),
      .dIn     (resVal),
      .qOut    (accQ[a])
    );
  end

  assign accA = accQ[0];
  assign accB = accQ[1];

  // Field read port
  assign rdSrc = rdSel ? accQ[1] : accQ[0];

  always_comb begin
    case (field_e'(rdField))
      FLD_FULL:  rdData = rdSrc;
      FLD_WORD:  rdData = {{GUARD_W{1'b0}}, rdSrc[DBL_W-1:0]};
      FLD_HIGH:  rdData = {{EXT_N{1'b0}}, rdSrc[DBL_W-1:WORD_W]};
      FLD_LOW:   rdData = {{EXT_N{1'b0}}, rdSrc[WORD_W-1:0]};
      FLD_GUARD: rdData = {{DBL_W{1'b0}}, rdSrc[ACC_W-1:DBL_W]};
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/dual_acc_alu.sv
module dual_acc_alu
  import dual_acc_pkg::*;
#(
  parameter int WORD_W  = DEF_WORD_W,
  parameter int GUARD_W = DEF_GUARD_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [2:0]                   aluOp,
  input  logic [2:0]                   srcSel,
  input  logic                         dstSel,
  input  logic [2:0]                   fieldSel,
  input  logic                         splitMode,
  input  logic                         signExt,
  input  logic [WORD_W-1:0]            immVal,
  input  logic [WORD_W-1:0]            memWord,
  input  logic [WORD_W-1:0]            tempReg,
  input  logic [WORD_W-1:0]            pairHi,
  input  logic [WORD_W-1:0]            pairLo,
  input  logic [2*WORD_W-1:0]          memLong,
  input  logic                         rdSel,
  input  logic [2:0]                   rdField,
  output logic [GUARD_W+2*WORD_W-1:0]  accA,
  output logic [GUARD_W+2*WORD_W-1:0]  accB,
  output logic [GUARD_W+2*WORD_W-1:0]  rdData
);

  strobe_t strobe;

  acc_alu_ctrl uCtrl (
    .wrEn      (wrEn),
    .aluOp     (aluOp),
    .dstSel    (dstSel),
    .fieldSel  (fieldSel),
    .splitMode (splitMode),
    .strobe    (strobe)
  );

  acc_alu_dp #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcSel  (srcSel),
    .dstSel  (dstSel),
    .signExt (signExt),
    .immVal  (immVal),
    .memWord (memWord),
    .tempReg (tempReg),
    .pairHi  (pairHi),
    .pairLo  (pairLo),
    .memLong (memLong),
    .rdSel   (rdSel),
    .rdField (rdField),
    .accA    (accA),
    .accB    (accB),
    .rdData  (rdData)
  );

endmodule

// File: rtl/dual_acc_alu_chk.sv
module dual_acc_alu_chk #(
  parameter int WORD_W  = 16,
  parameter int GUARD_W = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         wrEn,
  input logic [2:0]                   aluOp,
  input logic [2:0]                   srcSel,
  input logic                         dstSel,
  input logic [2:0]                   fieldSel,
  input logic                         splitMode,
  input logic [GUARD_W+2*WORD_W-1:0]  accA,
  input logic [GUARD_W+2*WORD_W-1:0]  accB
);

  localparam int DBL_W = 2 * WORD_W;
  localparam int ACC_W = GUARD_W + DBL_W;

  // R7: idle cycle leaves both accumulators alone
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(accA) && $stable(accB)));

  // R6: a write to A never touches B
  a_r6_b_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !dstSel) |=> $stable(accB));

  // R6: a write to B never touches A
  a_r6_a_untouched: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && dstSel) |=> $stable(accA));

  // R8: low-word write keeps guard and high word
  a_r8_low_only: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !splitMode && fieldSel == 3'd3 && !dstSel) |=> $stable(accA[ACC_W-1:WORD_W]));

  // R9: split write keeps the guard field
  a_r9_split_guard: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && splitMode && !dstSel) |=> $stable(accA[ACC_W-1:DBL_W]));

  // R10: full move of B into A copies it exactly
  a_r10_copy_b_to_a: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && aluOp == 3'd5 && srcSel == 3'd6 && !dstSel && fieldSel == 3'd0 && !splitMode)
    |=> (accA == $past(accB)));

endmodule

bind dual_acc_alu dual_acc_alu_chk #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .aluOp     (aluOp),
  .srcSel    (srcSel),
  .dstSel    (dstSel),
  .fieldSel  (fieldSel),
  .splitMode (splitMode),
  .accA      (accA),
  .accB      (accB)
);

// File: tb/tb_dual_acc_alu.sv
module tb_dual_acc_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  aluOp = '0;
  logic [2:0]  srcSel = '0;
  logic        dstSel = 1'b0;
  logic [2:0]  fieldSel = '0;
  logic        splitMode = 1'b0;
  logic        signExt = 1'b0;
  logic [15:0] immVal = '0;
  logic [15:0] memWord = '0;
  logic [15:0] tempReg = '0;
  logic [15:0] pairHi = '0;
  logic [15:0] pairLo = '0;
  logic [31:0] memLong = '0;
  logic        rdSel = 1'b0;
  logic [2:0]  rdField = '0;
  logic [39:0] accA;
  logic [39:0] accB;
  logic [39:0] rdData;

  int checks = 0;
  int errors = 0;

  logic [39:0] expA = '0;
  logic [39:0] expB = '0;
  logic [39:0] qA[$];
  logic [39:0] qB[$];
  string       qTag[$];

  always #10 clk = ~clk;

  dual_acc_alu dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .aluOp(aluOp), .srcSel(srcSel),
    .dstSel(dstSel), .fieldSel(fieldSel), .splitMode(splitMode), .signExt(signExt),
    .immVal(immVal), .memWord(memWord), .tempReg(tempReg), .pairHi(pairHi),
    .pairLo(pairLo), .memLong(memLong), .rdSel(rdSel), .rdField(rdField),
    .accA(accA), .accB(accB), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] model(input logic [2:0] op, input logic [39:0] a,
                                        input logic [39:0] b);
    case (op)
      3'd0:    model = a + b;
      3'd1:    model = a - b;
      3'd2:    model = a & b;
      3'd3:    model = a | b;
      3'd4:    model = a ^ b;
      default: model = b;
    endcase
  endfunction

  // Driver: presents one operation and pushes the expected accumulators
  task automatic issue(input logic [2:0] op, input logic [2:0] src, input logic dst,
                       input logic [2:0] fld, input logic split, input logic sx,
                       input logic we, input logic [15:0] im, input logic [15:0] m16,
                       input logic [15:0] t16, input logic [15:0] ph,
                       input logic [15:0] pl, input logic [31:0] m32, input string tag);
    logic [39:0] opnd, d, r, mask, hiR, loR, nxtA, nxtB;
    logic [15:0] oh, ol;
    logic        commit;
    @(negedge clk);
    wrEn = we; aluOp = op; srcSel = src; dstSel = dst; fieldSel = fld;
    splitMode = split; signExt = sx; immVal = im; memWord = m16; tempReg = t16;
    pairHi = ph; pairLo = pl; memLong = m32;
    d = dst ? expB : expA;
    case (src)
      3'd0: begin opnd = {{24{sx & im[15]}}, im};   oh = im;  ol = im;  end
      3'd1: begin opnd = {{24{sx & m16[15]}}, m16}; oh = m16; ol = m16; end
      3'd2: begin opnd = {{24{sx & t16[15]}}, t16}; oh = t16; ol = t16; end
      3'd3: begin opnd = {{8{sx & ph[15]}}, ph, pl}; oh = ph; ol = pl; end
      3'd4: begin opnd = {{8{sx & m32[31]}}, m32}; oh = m32[31:16]; ol = m32[15:0]; end
      3'd5: begin opnd = expA; oh = expA[31:16]; ol = expA[15:0]; end
      3'd6: begin opnd = expB; oh = expB[31:16]; ol = expB[15:0]; end
      default: begin opnd = '0; oh = '0; ol = '0; end
    endcase
    if (split) begin
      hiR  = model(op, {24'd0, d[31:16]}, {24'd0, oh});
      loR  = model(op, {24'd0, d[15:0]}, {24'd0, ol});
      r    = {d[39:32], hiR[15:0], loR[15:0]};
      mask = 40'h00_FFFF_FFFF;
    end else begin
      r = model(op, d, opnd);
      case (fld)
        3'd0:    mask = 40'hFF_FFFF_FFFF;
        3'd1:    mask = 40'h00_FFFF_FFFF;
        3'd2:    mask = 40'h00_FFFF_0000;
        3'd3:    mask = 40'h00_0000_FFFF;
        3'd4:    mask = 40'hFF_0000_0000;
        default: mask = 40'h0;
      endcase
    end
    commit = we && (op <= 3'd5) && (split || fld <= 3'd4);
    nxtA = expA;
    nxtB = expB;
    if (commit) begin
      if (dst) nxtB = (expB & ~mask) | (r & mask);
      else     nxtA = (expA & ~mask) | (r & mask);
    end
    #1;
    check({"R12 before edge accA ", tag}, accA, expA);
    check({"R12 before edge accB ", tag}, accB, expB);
    qA.push_back(nxtA);
    qB.push_back(nxtB);
    qTag.push_back(tag);
    expA = nxtA;
    expB = nxtB;
    @(posedge clk);
    #2;
    wrEn = 1'b0;
  endtask

  // Monitor: compares the accumulators after the edge that consumed an item
  initial begin
    forever begin
      @(posedge clk);
      if (qA.size() > 0) begin
        logic [39:0] eA, eB;
        string t;
        #5;
        eA = qA.pop_front();
        eB = qB.pop_front();
        t  = qTag.pop_front();
        check({t, " accA"}, accA, eA);
        check({t, " accB"}, accB, eB);
      end
    end
  end

  task automatic rdCheck(input logic sel, input logic [2:0] fld);
    logic [39:0] src, exp;
    @(negedge clk);
    rdSel = sel;
    rdField = fld;
    src = sel ? expB : expA;
    case (fld)
      3'd0:    exp = src;
      3'd1:    exp = {8'd0, src[31:0]};
      3'd2:    exp = {24'd0, src[31:16]};
      3'd3:    exp = {24'd0, src[15:0]};
      3'd4:    exp = {32'd0, src[39:32]};
      default: exp = '0;
    endcase
    #1;
    check("R11 read port", rdData, exp);
  endtask

  task automatic finish();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset accA", accA, 40'd0);
    check("R1 reset accB", accB, 40'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release accA", accA, 40'd0);
    check("R1 after release accB", accB, 40'd0);

    // R2 extension of narrow operands
    issue(3'd5, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 16'h8000, 0, 0, 0, 0, 0, "R2 sign-ext imm");
    issue(3'd5, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 16'h8000, 0, 0, 0, 0, 0, "R2 zero-ext imm");
    issue(3'd5, 3'd2, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 0, 0, 16'hC001, 0, 0, 0, "R2 sign-ext treg");
    // R3 wide operands
    issue(3'd5, 3'd4, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 0, 0, 0, 0, 0, 32'h8000_1234, "R3 mem32 sign");
    issue(3'd5, 3'd3, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 0, 0, 0, 16'h9234, 16'hABCD, 0, "R3 pair zero");
    // R4 arithmetic with guard carry and borrow
    issue(3'd0, 3'd4, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, "R4 add carry into guard");
    issue(3'd1, 3'd1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 0, 16'h0001, 0, 0, 0, 0, "R4 sub");
    issue(3'd5, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0000, 0, 0, 0, 0, 0, "R4 clear A");
    issue(3'd1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0001, 0, 0, 0, 0, 0, "R4 borrow wraps to all ones");
    // R5 Boolean operations
    issue(3'd2, 3'd4, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 32'h0F0F_F0F0, "R5 and");
    issue(3'd3, 3'd0, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 16'h8421, 0, 0, 0, 0, 0, "R5 or");
    issue(3'd4, 3'd4, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 0, 0, 0, 0, 0, 32'hFFFF_0000, "R5 xor");
    // R6 destination select
    issue(3'd0, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0010, 0, 0, 0, 0, 0, "R6 write B only");
    // R7 no write conditions
    issue(3'd0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 16'h1111, 0, 0, 0, 0, 0, "R7 wrEn low");
    issue(3'd6, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 16'h2222, 0, 0, 0, 0, 0, "R7 reserved op");
    issue(3'd5, 3'd0, 1'b1, 3'd6, 1'b0, 1'b0, 1'b1, 16'h3333, 0, 0, 0, 0, 0, "R7 reserved field");
    // R8 field writes
    issue(3'd5, 3'd1, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1, 0, 16'hBEEF, 0, 0, 0, 0, "R8 low word");
    issue(3'd5, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 16'h5A5A, 0, 0, 0, 0, 0, "R8 high word");
    issue(3'd5, 3'd0, 1'b0, 3'd4, 1'b0, 1'b1, 1'b1, 16'h8000, 0, 0, 0, 0, 0, "R8 guard field");
    issue(3'd5, 3'd4, 1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 0, 0, 0, 0, 0, 32'hCAFE_0123, "R8 word32");
    // R9 split mode
    issue(3'd5, 3'd3, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 0, 0, 0, 16'h0001, 16'hFFFF, 0, "R9 split load");
    issue(3'd0, 3'd0, 1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 16'h0001, 0, 0, 0, 0, 0, "R9 split add no carry");
    issue(3'd1, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 16'h0001, 0, 0, 0, 0, 0, "R9 split sub no borrow");
    issue(3'd4, 3'd6, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 0, 0, 0, 0, 0, 0, "R9 split xor acc");
    // R10 accumulator sources
    issue(3'd5, 3'd5, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 0, "R10 copy A to B");
    issue(3'd0, 3'd6, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 0, "R10 add B to A");
    issue(3'd5, 3'd6, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 0, "R10 copy B to A");
    issue(3'd5, 3'd0, 1'b1, 3'd0, 1'b0, 1'b1, 1'b1, 16'hF00D, 0, 0, 0, 0, 0, "R10 reload B");

    // R11 read port
    for (int f = 0; f < 8; f++) begin
      rdCheck(1'b0, 3'(f));
      rdCheck(1'b1, 3'(f));
    end

    wait (qA.size() == 0);
    repeat (2) @(negedge clk);
    finish();
  end

endmodule